// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Sharing Policies

This block keeps the in-flight instructions of several hardware threads in program order. Each thread owns a circular queue. Every entry holds a global sequence number and a ready flag. Dispatch appends an entry to one thread's queue. Another block sets the ready flag through a mark port, by thread and sequence number. Retirement pops a thread's head entry, but only once that entry is ready. The block reports:
- free space, both overall and for each thread;
- whether any active thread could commit this cycle;
- the oldest head entry across the active threads.

A sharing policy sets how many entries each thread may hold. Code 0 (shared) lets every thread use the whole capacity. Code 1 (split) divides the capacity evenly among the active threads. Code 2 (limit) caps each thread at a programmable threshold, except that a thread running alone gets the whole capacity.

The caps are computed by a small state machine with two states:
- In CAP_SETTLED the caps hold steady.
- When the policy, threshold or active mask differs from the stored copy, the machine records the new values and moves to CAP_REBAL.
- In CAP_REBAL it loads the recomputed caps. It returns to CAP_SETTLED, or stays in CAP_REBAL if the configuration has changed again.

Top module: `mt_rob`

## Requirements
- R1: Under policy code 0, every thread's cap equals the total capacity TOTAL (12 by default).
- R2: Under policy code 1, each active thread's cap is TOTAL divided by the number of active threads. An inactive thread's cap is TOTAL divided by NT. With no thread active, every cap is TOTAL divided by NT.
- R3: Under policy code 2, each cap is the threshold input, clamped to TOTAL. When exactly one thread is active, that thread's cap is TOTAL.
- R4: The free count for a thread is its cap minus its occupancy, floored at 0. The global free count is TOTAL minus the total occupancy.
- R5: An accepted insert appends the entry at the tail of its thread's queue. Both the thread's free count and the global free count drop by one on the next edge.
- R6: An insert is rejected when any of these holds: the thread is at or above its cap, the whole buffer is full, or the thread id is at least NT. The rejection shows on `ins_reject_o` in the same cycle, and no count changes.
- R7: A retire request pops the head of the named thread only when that head is ready. In the same cycle, `retire_ok_o` is 1 and `retire_seq_o` carries the head's sequence number. A request whose head is not ready has no effect.
- R8: A thread holding no entries reports its head as not ready.
- R9: A mark sets the ready flag of the valid entry, in the named thread, whose sequence number matches. Entries of other threads are not affected.
- R10: `commit_possible_o` is 1 exactly when some active thread has a ready head.
- R11: The oldest head is the head with the lowest sequence number among active, non-empty threads. `oldest_valid_o` is 0 when no such thread exists.
- R12: After a change of policy, threshold or active mask, the caps stay unchanged at the first clock edge and take their new values at the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Sharing policy: 0 shared, 1 split, 2 limit (3 acts as shared) |
| threshold_i | input | CW | Per-thread limit used by policy 2 |
| active_i | input | NT | One bit per thread, 1 = active |
| ins_valid_i | input | 1 | Insert request |
| ins_tid_i | input | TW | Thread of the insert |
| ins_seq_i | input | SW | Sequence number of the inserted entry |
| ins_reject_o | output | 1 | Insert refused in this cycle |
| mark_valid_i | input | 1 | Mark-ready request |
| mark_tid_i | input | TW | Thread of the mark |
| mark_seq_i | input | SW | Sequence number to mark ready |
| retire_valid_i | input | 1 | Retire request |
| retire_tid_i | input | TW | Thread to retire from |
| retire_ok_o | output | 1 | Head retired in this cycle |
| retire_seq_o | output | SW | Sequence number of the retired head (0 if none) |
| head_ready_o | output | NT | Per-thread head-ready flag |
| commit_possible_o | output | 1 | Some active thread has a ready head |
| free_total_o | output | CW | Global free entries |
| free_thread_o | output | NT*CW | Per-thread free entries, thread t in bits [t*CW +: CW] |
| oldest_valid_o | output | 1 | Oldest head exists |
| oldest_tid_o | output | TW | Thread holding the oldest head |
| oldest_seq_o | output | SW | Sequence number of the oldest head |

## Verification
The properties assume a few things about the inputs:
- Sequence numbers handed to the block rise over time and are never reused while still held, so "lowest" means "oldest" and a mark hits at most one entry.
- An insert and a retire in the same cycle would cancel in the global count. The properties on count change therefore exclude that case instead of modelling it.

The stimulus meets these assumptions. It issues one request per cycle, gives every insert a fresh, larger sequence number, and after every configuration change waits until the caps have settled before relying on them.

// File: rtl/mt_rob_pkg.sv
package mt_rob_pkg;

    typedef enum logic [1:0] {
        POL_SHARED = 2'd0,
        POL_SPLIT  = 2'd1,
        POL_LIMIT  = 2'd2
    } share_pol_e;

    typedef enum logic {
        CAP_SETTLED = 1'b0,
        CAP_REBAL   = 1'b1
    } cap_state_e;

endpackage

// File: rtl/mt_rob_cap_ctrl.sv
module mt_rob_cap_ctrl
    import mt_rob_pkg::*;
#(
    parameter int NT    = 3,
    parameter int TOTAL = 12,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy_i,
    input  logic [CW-1:0]    threshold_i,
    input  logic [NT-1:0]    active_i,
    output logic [NT*CW-1:0] caps_o
);

    cap_state_e    st_q, st_nx;
    logic [1:0]    snap_pol_q;
    logic [CW-1:0] snap_thr_q;
    logic [NT-1:0] snap_act_q;
    logic          changed;
    logic [NT*CW-1:0] caps_calc;

    assign changed = (policy_i != snap_pol_q) || (threshold_i != snap_thr_q)
                  || (active_i != snap_act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CAP_REBAL;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            CAP_SETTLED: st_nx = changed ? CAP_REBAL : CAP_SETTLED;
            CAP_REBAL:   st_nx = changed ? CAP_REBAL : CAP_SETTLED;
            default:     st_nx = CAP_REBAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_pol_q <= '0;
            snap_thr_q <= '0;
            snap_act_q <= '0;
        end else if (changed) begin
            snap_pol_q <= policy_i;
            snap_thr_q <= threshold_i;
            snap_act_q <= active_i;
        end
    end

    always_comb begin
        int            n_act;
        logic [CW-1:0] share;
        logic [CW-1:0] thr;
        n_act = 0;
        for (int t = 0; t < NT; t++) n_act += int'(snap_act_q[t]);
        share = CW'(TOTAL / NT);
        for (int k = 1; k <= NT; k++)
            if (n_act == k) share = CW'(TOTAL / k);
        thr = (snap_thr_q > CW'(TOTAL)) ? CW'(TOTAL) : snap_thr_q;
        for (int t = 0; t < NT; t++) begin
            unique case (share_pol_e'(snap_pol_q))
                POL_SPLIT:
                    caps_calc[t*CW +: CW] = snap_act_q[t] ? share : CW'(TOTAL / NT);
                POL_LIMIT:
                    caps_calc[t*CW +: CW] = (n_act == 1 && snap_act_q[t]) ? CW'(TOTAL) : thr;
                default:
                    caps_calc[t*CW +: CW] = CW'(TOTAL);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) caps_o[t*CW +: CW] <= CW'(TOTAL);
        end else if (st_q == CAP_REBAL) begin
            caps_o <= caps_calc;
        end
    end

endmodule

// File: rtl/mt_rob_tq.sv
module mt_rob_tq #(
    parameter int DEPTH = 12,
    parameter int SW    = 8,
    parameter int CW    = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [SW-1:0] push_seq_i,
    input  logic          mark_i,
    input  logic [SW-1:0] mark_seq_i,
    input  logic          pop_i,
    output logic [CW-1:0] count_o,
    output logic [SW-1:0] head_seq_o,
    output logic          head_rdy_o
);

    logic [SW-1:0]    seq_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] rdy_q;
    logic [PW-1:0]    hd_q, tl_q;
    logic [CW-1:0]    cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            rdy_q <= '0;
            hd_q  <= '0;
            tl_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) seq_q[i] <= '0;
        end else begin
            if (mark_i) begin
                for (int i = 0; i < DEPTH; i++)
                    if (vld_q[i] && seq_q[i] == mark_seq_i) rdy_q[i] <= 1'b1;
            end
            if (pop_i) begin
                vld_q[hd_q] <= 1'b0;
                rdy_q[hd_q] <= 1'b0;
                hd_q        <= bump(hd_q);
            end
            if (push_i) begin
                seq_q[tl_q] <= push_seq_i;
                vld_q[tl_q] <= 1'b1;
                rdy_q[tl_q] <= 1'b0;
                tl_q        <= bump(tl_q);
            end
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
        end
    end

    assign count_o    = cnt_q;
    assign head_seq_o = seq_q[hd_q];
    assign head_rdy_o = (cnt_q != '0) && rdy_q[hd_q];

endmodule

// File: rtl/mt_rob_oldest.sv
module mt_rob_oldest #(
    parameter int NT = 3,
    parameter int SW = 8,
    parameter int TW = 2
) (
    input  logic [NT-1:0]    cand_i,
    input  logic [NT*SW-1:0] seqs_i,
    output logic             valid_o,
    output logic [TW-1:0]    tid_o,
    output logic [SW-1:0]    seq_o
);

    always_comb begin
        valid_o = 1'b0;
        tid_o   = '0;
        seq_o   = '0;
        for (int t = 0; t < NT; t++) begin
            if (cand_i[t] && (!valid_o || seqs_i[t*SW +: SW] < seq_o)) begin
                valid_o = 1'b1;
                tid_o   = TW'(t);
                seq_o   = seqs_i[t*SW +: SW];
            end
        end
    end

endmodule

// File: rtl/mt_rob.sv
module mt_rob #(
    parameter int NT    = 3,
    parameter int TOTAL = 12,
    parameter int SW    = 8,
    localparam int CW   = $clog2(TOTAL + 1),
    localparam int TW   = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy_i,
    input  logic [CW-1:0]    threshold_i,
    input  logic [NT-1:0]    active_i,
    input  logic             ins_valid_i,
    input  logic [TW-1:0]    ins_tid_i,
    input  logic [SW-1:0]    ins_seq_i,
    output logic             ins_reject_o,
    input  logic             mark_valid_i,
    input  logic [TW-1:0]    mark_tid_i,
    input  logic [SW-1:0]    mark_seq_i,
    input  logic             retire_valid_i,
    input  logic [TW-1:0]    retire_tid_i,
    output logic             retire_ok_o,
    output logic [SW-1:0]    retire_seq_o,
    output logic [NT-1:0]    head_ready_o,
    output logic             commit_possible_o,
    output logic [CW-1:0]    free_total_o,
    output logic [NT*CW-1:0] free_thread_o,
    output logic             oldest_valid_o,
    output logic [TW-1:0]    oldest_tid_o,
    output logic [SW-1:0]    oldest_seq_o
);

    logic [NT*CW-1:0] caps;
    logic [NT*CW-1:0] occ_flat;
    logic [NT*SW-1:0] head_seq_flat;
    logic [NT-1:0]    push_v, pop_v, mark_v, nonempty;
    logic [CW-1:0]    occ_total;
    logic             ins_ok;

    mt_rob_cap_ctrl #(.NT(NT), .TOTAL(TOTAL), .CW(CW)) u_caps (
        .clk         (clk),
        .rst_n       (rst_n),
        .policy_i    (policy_i),
        .threshold_i (threshold_i),
        .active_i    (active_i),
        .caps_o      (caps)
    );

    for (genvar t = 0; t < NT; t++) begin : g_thr
        assign push_v[t] = ins_ok && (ins_tid_i == TW'(t));
        assign mark_v[t] = mark_valid_i && (mark_tid_i == TW'(t));
        assign pop_v[t]  = retire_valid_i && (retire_tid_i == TW'(t)) && head_ready_o[t];

        mt_rob_tq #(.DEPTH(TOTAL), .SW(SW), .CW(CW)) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_i     (push_v[t]),
            .push_seq_i (ins_seq_i),
            .mark_i     (mark_v[t]),
            .mark_seq_i (mark_seq_i),
            .pop_i      (pop_v[t]),
            .count_o    (occ_flat[t*CW +: CW]),
            .head_seq_o (head_seq_flat[t*SW +: SW]),
            .head_rdy_o (head_ready_o[t])
        );

        assign nonempty[t] = occ_flat[t*CW +: CW] != '0;
        assign free_thread_o[t*CW +: CW] =
            (caps[t*CW +: CW] > occ_flat[t*CW +: CW])
                ? caps[t*CW +: CW] - occ_flat[t*CW +: CW] : '0;
    end

    always_comb begin
        occ_total = '0;
        for (int t = 0; t < NT; t++) occ_total = occ_total + occ_flat[t*CW +: CW];
    end

    always_comb begin
        ins_ok = 1'b0;
        for (int t = 0; t < NT; t++)
            if (ins_valid_i && ins_tid_i == TW'(t)
                && occ_flat[t*CW +: CW] < caps[t*CW +: CW]
                && occ_total < CW'(TOTAL))
                ins_ok = 1'b1;
    end

    always_comb begin
        retire_seq_o = '0;
        for (int t = 0; t < NT; t++)
            if (pop_v[t]) retire_seq_o = head_seq_flat[t*SW +: SW];
    end

    assign ins_reject_o      = ins_valid_i && !ins_ok;
    assign retire_ok_o       = |pop_v;
    assign commit_possible_o = |(head_ready_o & active_i);
    assign free_total_o      = CW'(TOTAL) - occ_total;

    mt_rob_oldest #(.NT(NT), .SW(SW), .TW(TW)) u_oldest (
        .cand_i  (nonempty & active_i),
        .seqs_i  (head_seq_flat),
        .valid_o (oldest_valid_o),
        .tid_o   (oldest_tid_o),
        .seq_o   (oldest_seq_o)
    );

endmodule

// File: rtl/mt_rob_checker.sv
module mt_rob_checker #(
    parameter int NT    = 3,
    parameter int TOTAL = 12,
    parameter int SW    = 8,
    parameter int CW    = 4,
    parameter int TW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ins_valid_i,
    input logic          ins_reject_o,
    input logic [TW-1:0] retire_tid_i,
    input logic          retire_ok_o,
    input logic [SW-1:0] retire_seq_o,
    input logic [NT-1:0] head_ready_o,
    input logic          commit_possible_o,
    input logic [CW-1:0] free_total_o,
    input logic          oldest_valid_o
);

    p_full_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_i && free_total_o == '0) |-> ins_reject_o);

    p_reject_keeps_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_reject_o && !retire_ok_o) |=> free_total_o == $past(free_total_o));

    p_insert_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_i && !ins_reject_o && !retire_ok_o)
            |=> free_total_o == $past(free_total_o) - 1'b1);

    p_retire_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retire_ok_o |-> |(head_ready_o & (NT'(1) << retire_tid_i)));

    p_retire_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_ok_o && !ins_valid_i) |=> free_total_o == $past(free_total_o) + 1'b1);

    p_no_seq_without_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_ok_o |-> retire_seq_o == '0);

    p_empty_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (free_total_o == CW'(TOTAL)) |-> head_ready_o == '0);

    p_free_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        free_total_o <= CW'(TOTAL));

    p_oldest_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !oldest_valid_o |-> !commit_possible_o);

endmodule

bind mt_rob mt_rob_checker #(.NT(NT), .TOTAL(TOTAL), .SW(SW), .CW(CW), .TW(TW)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .ins_valid_i       (ins_valid_i),
    .ins_reject_o      (ins_reject_o),
    .retire_tid_i      (retire_tid_i),
    .retire_ok_o       (retire_ok_o),
    .retire_seq_o      (retire_seq_o),
    .head_ready_o      (head_ready_o),
    .commit_possible_o (commit_possible_o),
    .free_total_o      (free_total_o),
    .oldest_valid_o    (oldest_valid_o)
);

// File: tb/mt_rob_bench.sv
`timescale 1ns/1ps
module mt_rob_bench;

    localparam int NT = 3, TOTAL = 12, SW = 8;
    localparam int CW = $clog2(TOTAL + 1);
    localparam int TW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] policy_i = 2'd0;
    logic [CW-1:0] threshold_i = '0;
    logic [NT-1:0] active_i = 3'b111;
    logic ins_valid_i = 0, mark_valid_i = 0, retire_valid_i = 0;
    logic [TW-1:0] ins_tid_i = 0, mark_tid_i = 0, retire_tid_i = 0;
    logic [SW-1:0] ins_seq_i = 0, mark_seq_i = 0;
    logic ins_reject_o, retire_ok_o, commit_possible_o, oldest_valid_o;
    logic [SW-1:0] retire_seq_o, oldest_seq_o;
    logic [NT-1:0] head_ready_o;
    logic [CW-1:0] free_total_o;
    logic [NT*CW-1:0] free_thread_o;
    logic [TW-1:0] oldest_tid_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    mt_rob u_mt_rob (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int fthr(input int t);
        return int'(free_thread_o[t*CW +: CW]);
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic ins(input int tid, input int seq, input bit exp_rej, input string tag);
        ins_valid_i = 1; ins_tid_i = TW'(tid); ins_seq_i = SW'(seq);
        #2 chk(tag, int'(ins_reject_o), int'(exp_rej));
        tick();
        ins_valid_i = 0;
    endtask

    task automatic mark(input int tid, input int seq);
        mark_valid_i = 1; mark_tid_i = TW'(tid); mark_seq_i = SW'(seq);
        tick();
        mark_valid_i = 0;
    endtask

    task automatic retire(input int tid, input bit exp_ok, input int exp_seq, input string tag);
        if (exp_ok) exp_q.push_back(exp_seq);
        retire_valid_i = 1; retire_tid_i = TW'(tid);
        #2 chk(tag, int'(retire_ok_o), int'(exp_ok));
        tick();
        retire_valid_i = 0;
    endtask

    task automatic cfg(input int pol, input int thr, input int act);
        policy_i = 2'(pol); threshold_i = CW'(thr); active_i = NT'(act);
        repeat (3) tick();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && retire_ok_o) begin
            if (exp_q.size() == 0) chk("R7 unexpected retire", int'(retire_seq_o), -1);
            else chk("R7 retired seq order", int'(retire_seq_o), exp_q.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        repeat (3) tick();
        // reset state
        chk("R4 reset free_total", int'(free_total_o), 12);
        chk("R1 reset free t0", fthr(0), 12);
        chk("R8 reset head ready", int'(head_ready_o), 0);
        chk("R11 reset oldest valid", int'(oldest_valid_o), 0);
        chk("R10 reset commit", int'(commit_possible_o), 0);

        ins(0, 10, 0, "R5 ins t0");
        ins(1, 5, 0, "R5 ins t1");
        ins(2, 20, 0, "R5 ins t2");
        chk("R5 free_total", int'(free_total_o), 9);
        chk("R1 free t0", fthr(0), 11);
        chk("R11 oldest tid", int'(oldest_tid_o), 1);
        chk("R11 oldest seq", int'(oldest_seq_o), 5);

        retire(1, 0, 0, "R7 retire not ready");
        chk("R7 free unchanged", int'(free_total_o), 9);

        mark(1, 5);
        chk("R9 head ready t1", int'(head_ready_o[1]), 1);
        chk("R10 commit after mark", int'(commit_possible_o), 1);
        retire(1, 1, 5, "R7 retire t1");
        chk("R8 t1 empty not ready", int'(head_ready_o[1]), 0);
        chk("R11 oldest after retire", int'(oldest_seq_o), 10);

        mark(2, 20);
        active_i = 3'b011; tick();
        chk("R10 inactive ready ignored", int'(commit_possible_o), 0);
        active_i = 3'b110; tick();
        chk("R11 oldest skips inactive", int'(oldest_seq_o), 20);
        chk("R10 commit t2 active", int'(commit_possible_o), 1);
        active_i = 3'b111; repeat (3) tick();

        // cap timing then split policy
        policy_i = 2'd1; tick();
        chk("R12 cap unchanged first edge", fthr(0), 11);
        tick();
        chk("R12 cap at second edge", fthr(0), 3);
        tick();
        ins(0, 11, 0, "R5 ins split");
        ins(0, 12, 0, "R5 ins split");
        ins(0, 13, 0, "R5 ins split");
        chk("R2 free t0 at cap", fthr(0), 0);
        ins(0, 14, 1, "R6 reject at cap");
        chk("R6 free_total kept", int'(free_total_o), 7);
        cfg(1, 0, 3'b011);
        chk("R2 two active t0", fthr(0), 2);
        chk("R2 two active t1", fthr(1), 6);
        chk("R2 inactive t2", fthr(2), 3);

        cfg(2, 2, 3'b111);
        chk("R3 over cap floors", fthr(0), 0);
        chk("R3 limit t1", fthr(1), 2);
        ins(1, 30, 0, "R3 ins under limit");
        ins(1, 31, 0, "R3 ins under limit");
        ins(1, 32, 1, "R6 reject at limit");
        cfg(2, 2, 3'b010);
        chk("R3 sole active full", fthr(1), 10);
        chk("R3 others keep limit", fthr(0), 0);
        chk("R11 only t1 active", int'(oldest_seq_o), 30);

        cfg(0, 2, 3'b111);
        chk("R4 free_total mid", int'(free_total_o), 5);
        for (int s = 40; s < 45; s++) ins(2, s, 0, "R5 fill t2");
        chk("R4 free_total full", int'(free_total_o), 0);
        ins(1, 50, 1, "R6 reject full");
        chk("R1 t1 free while full", fthr(1), 10);
        ins(3, 51, 1, "R6 reject bad tid");

        mark(1, 10);
        chk("R9 other thread untouched", int'(head_ready_o[0]), 0);
        mark(0, 12);
        chk("R9 non-head mark", int'(head_ready_o[0]), 0);
        retire(0, 0, 0, "R7 head not ready");
        mark(0, 10); mark(0, 11); mark(0, 13);
        retire(0, 1, 10, "R7 retire order");
        retire(0, 1, 11, "R7 retire order");
        retire(0, 1, 12, "R7 retire order");
        retire(0, 1, 13, "R7 retire order");
        chk("R8 t0 drained", int'(head_ready_o[0]), 0);
        chk("R4 free after drain", int'(free_total_o), 4);
        retire(2, 1, 20, "R7 retire t2");
        chk("R8 next head not ready", int'(head_ready_o[2]), 0);
        chk("R11 oldest final", int'(oldest_seq_o), 30);
        repeat (2) tick();
        chk("R7 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule